// File: doc/BRIEF.md
# Selectable-Ratio CPU Clock Divider

This block makes the CPU clock from one of four source clocks: main, sub, internal oscillator and PLL. The sub source goes straight to the output. The other three sources go through a divider. A 5-bit code picks the division ratio from a fixed, irregular set that includes an odd divide-by-3. A bus-clock output carries the same waveform as the CPU clock.

Software writes the divide code through a one-cycle write strobe. A code outside the set is dropped, and the current ratio stays. A newly written ratio takes effect only when the current output period completes, so the output never shows a shortened pulse. The divider comes out of reset at divide-by-8. A strobe that marks entry to low power also resets it to divide-by-8, except when the internal oscillator is the selected source. The source mux is assumed to change only while the clocks are quiet. It gives no glitch protection when switching between asynchronous clocks.

Top module: `cpu_clk_div`

## Requirements
- R1: After reset the output runs at divide-by-8 of the selected source: a period of 8 source cycles, high for 4.
- R2: The divide code maps to these ratios: 5'b00001=/1 (output follows the source), 5'b00010=/2, 5'b00011=/3, 5'b00100=/4, 5'b00110=/6, 5'b01000=/8, 5'b01010=/10, 5'b01100=/12, 5'b01110=/14, 5'b00000=/16.
- R3: For even ratios the output is high for half of the period. At divide-by-3 it is high for 1 source cycle and low for 2.
- R4: A low-power entry strobe sets the code to 5'b01000 (divide-by-8) when src_sel is not 2'b10.
- R5: When src_sel is 2'b10 (internal oscillator), osc_is_src is 1 and the low-power strobe leaves the ratio unchanged. For any other src_sel, osc_is_src is 0.
- R6: A write of any code not listed in R2 is ignored, and the previous ratio stays.
- R7: A new ratio is applied only at the end of a full output period, so during a change every output period equals either the old ratio or the new ratio.
- R8: With src_sel 2'b01 (sub) the output follows the sub clock whatever the divide code. Encodings: 2'b00 is main, 2'b11 is PLL. Both of these are divided.
- R9: bus_clk carries the same waveform as cpu_clk at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_main | input | 1 | Main source clock |
| clk_sub | input | 1 | Sub source clock (undivided) |
| clk_osc | input | 1 | Internal oscillator clock |
| clk_pll | input | 1 | PLL clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_sel | input | 2 | Source select: 00 main, 01 sub, 10 oscillator, 11 PLL |
| code_wr | input | 1 | Divide-code write strobe |
| code_wdata | input | 5 | Divide code to write |
| lp_enter | input | 1 | Low-power entry strobe |
| osc_is_src | output | 1 | High when the internal oscillator is selected |
| cpu_clk | output | 1 | Divided CPU clock |
| bus_clk | output | 1 | Bus clock, same as cpu_clk |

## Verification
A wrong stored code or a wrong active ratio shows up as a wrong output period within one full output period after it settles. The bench therefore measures periods and high times in nanoseconds for every code. A counter that misses its boundary, or a ratio swapped in mid-period, produces a period that matches neither the old ratio nor the new one. The bench catches this by measuring several consecutive periods right after a write, starting from different phases. Low-power forcing and the ignoring of invalid codes are visible only through the period that follows, so each of these checks measures the output after the stimulus.

// File: rtl/cpu_clk_div.sv
`timescale 1ns/1ps
module cpu_clk_div #(
  parameter logic [4:0] RST_CODE = 5'b01000
) (
  input  logic       clk_main,
  input  logic       clk_sub,
  input  logic       clk_osc,
  input  logic       clk_pll,
  input  logic       rst_n,
  input  logic [1:0] src_sel,
  input  logic       code_wr,
  input  logic [4:0] code_wdata,
  input  logic       lp_enter,
  output logic       osc_is_src,
  output logic       cpu_clk,
  output logic       bus_clk
);
  localparam logic [1:0] SRC_SUB = 2'b01;
  localparam logic [1:0] SRC_OSC = 2'b10;

  function automatic logic [4:0] ratio_of(input logic [4:0] c);
    case (c)
      5'b00000: ratio_of = 5'd16;
      5'b00001: ratio_of = 5'd1;
      5'b00010: ratio_of = 5'd2;
      5'b00011: ratio_of = 5'd3;
      5'b00100: ratio_of = 5'd4;
      5'b00110: ratio_of = 5'd6;
      5'b01000: ratio_of = 5'd8;
      5'b01010: ratio_of = 5'd10;
      5'b01100: ratio_of = 5'd12;
      5'b01110: ratio_of = 5'd14;
      default:  ratio_of = 5'd0;
    endcase
  endfunction

  function automatic logic [4:0] high_len(input logic [4:0] r);
    high_len = (r == 5'd3) ? 5'd1 : (r >> 1);
  endfunction

  logic       sel_clk;
  logic [4:0] code_q, act_q;
  logic [3:0] cnt_q;
  logic       div_q;

  always_comb begin
    case (src_sel)
      2'b00:   sel_clk = clk_main;
      2'b01:   sel_clk = clk_sub;
      2'b10:   sel_clk = clk_osc;
      default: sel_clk = clk_pll;
    endcase
  end

  assign osc_is_src = (src_sel == SRC_OSC);

  wire       lp_force  = lp_enter && !osc_is_src;
  wire       wr_ok     = code_wr && (ratio_of(code_wdata) != 5'd0);
  wire [4:0] cnt_next  = {1'b0, cnt_q} + 5'd1;
  wire       last      = (cnt_next == act_q);

  always_ff @(posedge sel_clk or negedge rst_n) begin
    if (!rst_n)        code_q <= RST_CODE;
    else if (lp_force) code_q <= RST_CODE;
    else if (wr_ok)    code_q <= code_wdata;
  end

  always_ff @(posedge sel_clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= ratio_of(RST_CODE);
      cnt_q <= '0;
      div_q <= 1'b1;
    end else if (last) begin
      act_q <= ratio_of(code_q);
      cnt_q <= '0;
      div_q <= 1'b1;
    end else begin
      cnt_q <= cnt_q + 4'd1;
      div_q <= (cnt_next < high_len(act_q));
    end
  end

  assign cpu_clk = (src_sel == SRC_SUB) ? clk_sub :
                   (act_q == 5'd1)      ? sel_clk : div_q;
  assign bus_clk = cpu_clk;
endmodule

module cpu_clk_div_chk (
  input logic       sel_clk,
  input logic       rst_n,
  input logic [1:0] src_sel,
  input logic       lp_enter,
  input logic       code_wr,
  input logic [4:0] code_wdata,
  input logic [4:0] code_q,
  input logic [4:0] act_q,
  input logic [3:0] cnt_q,
  input logic       div_q,
  input logic       cpu_clk,
  input logic       bus_clk
);
  wire good_code = code_wdata inside {5'b00000, 5'b00001, 5'b00010, 5'b00011, 5'b00100,
                                      5'b00110, 5'b01000, 5'b01010, 5'b01100, 5'b01110};

  a_r4_lp_force: assert property (@(posedge sel_clk) disable iff (!rst_n)
    lp_enter && src_sel != 2'b10 |=> code_q == 5'b01000);

  a_r5_osc_keep: assert property (@(posedge sel_clk) disable iff (!rst_n)
    lp_enter && src_sel == 2'b10 && !code_wr |=> $stable(code_q));

  a_r6_bad_code: assert property (@(posedge sel_clk) disable iff (!rst_n)
    code_wr && !lp_enter && !good_code |=> $stable(code_q));

  a_r7_hold_mid: assert property (@(posedge sel_clk) disable iff (!rst_n)
    ({1'b0, cnt_q} + 5'd1 != act_q) |=> $stable(act_q));

  a_r7_cnt_range: assert property (@(posedge sel_clk) disable iff (!rst_n)
    {1'b0, cnt_q} < act_q);

  a_r3_third_duty: assert property (@(posedge sel_clk) disable iff (!rst_n)
    act_q == 5'd3 |-> div_q == (cnt_q == 4'd0));

  a_r9_bus_copy: assert property (@(posedge sel_clk) disable iff (!rst_n)
    bus_clk == cpu_clk);
endmodule

bind cpu_clk_div cpu_clk_div_chk u_chk (
  .sel_clk(sel_clk), .rst_n(rst_n), .src_sel(src_sel), .lp_enter(lp_enter),
  .code_wr(code_wr), .code_wdata(code_wdata), .code_q(code_q), .act_q(act_q),
  .cnt_q(cnt_q), .div_q(div_q), .cpu_clk(cpu_clk), .bus_clk(bus_clk)
);

// File: tb/cpu_clk_div_test.sv
`timescale 1ns/1ps
module cpu_clk_div_test;
  logic clk = 1'b0, clk_pll = 1'b0, clk_sub = 1'b0;
  logic rst_n = 1'b0, code_wr = 1'b0, lp_enter = 1'b0;
  logic [1:0] src_sel = 2'b00;
  logic [4:0] code_wdata = '0;
  logic osc_is_src, cpu_clk, bus_clk;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;
  initial begin #4; forever begin clk_pll = ~clk_pll; #8; end end
  initial begin #4; forever begin clk_sub = ~clk_sub; #20; end end

  cpu_clk_div uut (
    .clk_main(clk), .clk_sub(clk_sub), .clk_osc(clk), .clk_pll(clk_pll),
    .rst_n(rst_n), .src_sel(src_sel), .code_wr(code_wr), .code_wdata(code_wdata),
    .lp_enter(lp_enter), .osc_is_src(osc_is_src), .cpu_clk(cpu_clk), .bus_clk(bus_clk)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic meas(output int per, output int hi);
    realtime t0, t1, t2;
    @(posedge cpu_clk) t0 = $realtime;
    @(negedge cpu_clk) t1 = $realtime;
    @(posedge cpu_clk) t2 = $realtime;
    per = int'(t2 - t0);
    hi  = int'(t1 - t0);
  endtask

  task automatic wr(input logic [4:0] c);
    @(negedge clk); code_wr = 1'b1; code_wdata = c;
    @(negedge clk); code_wr = 1'b0;
  endtask

  task automatic lp();
    @(negedge clk); lp_enter = 1'b1;
    @(negedge clk); lp_enter = 1'b0;
  endtask

  task automatic settle();
    repeat (40) @(negedge clk);
  endtask

  function automatic int exp_ratio(input logic [4:0] c);
    case (c)
      5'b00000: return 16; 5'b00001: return 1;  5'b00010: return 2;
      5'b00011: return 3;  5'b00100: return 4;  5'b00110: return 6;
      5'b01000: return 8;  5'b01010: return 10; 5'b01100: return 12;
      5'b01110: return 14; default:  return 0;
    endcase
  endfunction

  function automatic int exp_hi_ns(input int r, input int tsrc);
    if (r == 1) return tsrc / 2;
    if (r == 3) return tsrc;
    return (r / 2) * tsrc;
  endfunction

  initial begin
    int p, h, r;
    logic [4:0] bad [4];
    bad[0] = 5'b00101; bad[1] = 5'b01001; bad[2] = 5'b11111; bad[3] = 5'b10000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset default
    meas(p, h);
    check("R1 reset period ns", p, 64);
    check("R1 reset high ns", h, 32);
    check("R5 flag on main", int'(osc_is_src), 0);
    // R2 / R3 every code on main
    for (int c = 0; c < 32; c++) begin
      r = exp_ratio(5'(c));
      if (r != 0) begin
        wr(5'(c)); settle();
        meas(p, h);
        check($sformatf("R2 period code %0d", c), p, r * 8);
        check($sformatf("R3 high code %0d", c), h, exp_hi_ns(r, 8));
        check("R9 bus equals cpu", int'(bus_clk), int'(cpu_clk));
      end
    end
    // R6 invalid codes
    wr(5'b00110); settle();
    foreach (bad[i]) begin
      wr(bad[i]); settle();
      meas(p, h);
      check($sformatf("R6 ignored code %0d", bad[i]), p, 48);
    end
    // R4 low-power forcing on main
    wr(5'b00010); settle();
    lp(); settle();
    meas(p, h);
    check("R4 forced period ns", p, 64);
    // R5 oscillator keeps ratio
    @(negedge clk); src_sel = 2'b10;
    settle();
    check("R5 flag on osc", int'(osc_is_src), 1);
    wr(5'b00100); settle();
    lp(); settle();
    meas(p, h);
    check("R5 no forcing on osc", p, 32);
    @(negedge clk); src_sel = 2'b00;
    settle();
    // R7 transitions from several phases
    for (int ph = 0; ph < 6; ph++) begin
      int oldr, newr;
      oldr = (ph % 2 == 0) ? 16 : 3;
      newr = (ph % 2 == 0) ? 2 : 10;
      wr(oldr == 16 ? 5'b00000 : 5'b00011); settle();
      repeat (ph * 3) @(negedge clk);
      wr(newr == 2 ? 5'b00010 : 5'b01010);
      for (int k = 0; k < 3; k++) begin
        meas(p, h);
        check($sformatf("R7 period in {old,new} phase %0d", ph),
              (p == oldr * 8 || p == newr * 8) ? 1 : 0, 1);
      end
      settle();
      meas(p, h);
      check("R7 new ratio applied", p, newr * 8);
    end
    // R8 PLL is divided, sub is not
    wr(5'b00011); settle();
    @(negedge clk); src_sel = 2'b11;
    repeat (60) @(negedge clk);
    meas(p, h);
    check("R8 pll period ns", p, 48);
    check("R3 pll third high ns", h, 16);
    @(negedge clk); src_sel = 2'b01;
    repeat (60) @(negedge clk);
    meas(p, h);
    check("R8 sub period ns", p, 40);
    check("R8 sub high ns", h, 20);
    check("R9 bus equals cpu on sub", int'(bus_clk), int'(cpu_clk));
    @(negedge clk); src_sel = 2'b00;
    settle();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule